// File: doc/BRIEF.md
# ADC Serial Slave Readout Port

This block is the device side of the serial result port on a 16-bit sampling converter, for the case where the host supplies the serial clock. The converter core hands over a parallel result with a one-cycle done pulse. The block then shifts that result out MSB first on the serial clock. The serial clock has effect only while chip select and read are both low. A configuration input picks which serial clock edge moves the output. The opposite edge samples a chain input. Several converters can therefore be cascaded: the upstream word follows the local LSB directly, with no gap.

The serial clock, chip select, read and chain input are sampled by the block's own system clock. Serial clock edges are found by comparing against the previous sample. Busy is held high from the start of conversion until all sixteen result bits have left the port. A host that reads after conversion can therefore treat the falling edge of busy as the end of the whole access.

Top module: `adc_serial_readout`

## Requirements
- R1: When `ext_mode` is 0, `sdo` stays 0, serial clock edges shift nothing, and a conversion-done pulse does not hold `busy` high.
- R2: A serial clock edge is ignored unless `cs_n` and `rd_n` are both 0. Edges seen while `rd_n` is 1 leave the bit position and `busy` unchanged.
- R3: When a read starts, `sdo` shows bit 15 of the result. Each shift edge then advances one bit toward bit 0, so sixteen shift edges deliver the whole result.
- R4: With `edge_sel` = 0, `sdo` changes only on serial clock falling edges. With `edge_sel` = 1, it changes only on rising edges. It holds its value across the other edge.
- R5: `chain_in` is sampled on the edge opposite the shift edge. After the local bit 0, the next shift edge presents the first sampled upstream bit, and upstream bits follow in order.
- R6: `busy` is 1 while `conv_active` is 1. A done pulse in external mode keeps `busy` at 1 until the sixteenth shift edge of the read, and `busy` falls after that edge.
- R7: The result is the same whether the serial clock idles high or low between accesses, for both values of `edge_sel`.
- R8: While `cs_n` is 1, the shift register reloads from the latest completed result and the bit position clears. A read cut short and started again begins from bit 15.
- R9: While `cs_n` is 1, and after reset, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all host signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 enables the slave readout port |
| edge_sel | input | 1 | Shift edge: 0 falling, 1 rising |
| conv_active | input | 1 | High while the core converts |
| conv_done | input | 1 | One-cycle pulse when `result` is valid |
| result | input | DATA_W | Completed conversion result |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| sclk | input | 1 | Host serial clock |
| chain_in | input | 1 | Serial data from the upstream device |
| sdo | output | 1 | Serial data output |
| busy | output | 1 | Conversion or unread result pending |

## Verification
A serial clock change applied between system clock edges is registered on the next rising system clock edge. `sdo` and `busy` show the effect right after that edge, so each result is due one system cycle after the stimulus. The bench holds every serial clock phase for two system cycles. It samples at the end of each phase: just before the next capture edge and just before the next shift edge. Each output bit is therefore compared twice, once on either side of the non-shifting edge. The sample taken after the sixteenth shift edge is where `busy` must read 0.

// File: rtl/adc_serial_readout.sv
module adc_serial_readout #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              edge_sel,
  input  logic              conv_active,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] result,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sclk,
  input  logic              chain_in,
  output logic              sdo,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              sclk_q, chain_q, pend, active_q;
  logic [DATA_W-1:0] res_q, sreg;
  logic [CNT_W-1:0]  bit_cnt;

  wire active   = ext_mode & ~cs_n & ~rd_n;
  wire rise     = sclk & ~sclk_q;
  wire fall     = ~sclk & sclk_q;
  wire shift_ev = active & (edge_sel ? rise : fall);
  wire cap_ev   = active & (edge_sel ? fall : rise);
  wire last_bit = shift_ev && (bit_cnt == CNT_W'(DATA_W - 1));

  assign sdo  = ext_mode & ~cs_n & sreg[DATA_W-1];
  assign busy = conv_active | pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
      chain_q  <= 1'b0;
      res_q    <= '0;
      sreg     <= '0;
      bit_cnt  <= '0;
      pend     <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      active_q <= active;
      if (conv_done) res_q <= result;
      if (cap_ev || (active && !active_q)) chain_q <= chain_in;
      if (cs_n) begin
        sreg    <= conv_done ? result : res_q;
        bit_cnt <= '0;
      end else if (shift_ev) begin
        sreg <= {sreg[DATA_W-2:0], chain_q};
        if (bit_cnt != CNT_W'(DATA_W)) bit_cnt <= bit_cnt + 1'b1;
      end
      if (ext_mode && conv_done) pend <= 1'b1;
      else if (last_bit) pend <= 1'b0;
    end
  end

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ext_mode && !shift_ev) |=> (cs_n || !ext_mode || $stable(sdo)));

  // R2
  gated_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_n || !ext_mode) && !cs_n) |=> $stable(bit_cnt));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0));

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && conv_done) |=> busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !last_bit) |=> busy);

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !sdo);
endmodule

// File: tb/adc_serial_readout_tb.sv
module adc_serial_readout_tb;
  logic clk = 0, rst_n = 0;
  logic ext_mode = 1, edge_sel = 0, conv_active = 0, conv_done = 0;
  logic [15:0] result = '0, up = '0;
  logic cs_n = 1, rd_n = 0, sclk = 0;
  logic sdo, busy;
  int checks = 0, errors = 0;
  bit exp_q[$];
  string tag_q[$];
  event sample_ev;

  always #2 clk = ~clk;

  adc_serial_readout #(.DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .edge_sel(edge_sel),
    .conv_active(conv_active), .conv_done(conv_done), .result(result),
    .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk), .chain_in(up[15]),
    .sdo(sdo), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input bit b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    -> sample_ev;
    #0;
  endtask

  initial forever begin
    @(sample_ev);
    #0;
    while (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(sdo === e, t, sdo, e);
    end
  end

  task automatic convert(input logic [15:0] v, input bit exp_busy);
    conv_active = 1;
    waitc(3);
    chk(busy === 1'b1, "R6 busy during conversion", busy, 1);
    conv_active = 0; conv_done = 1; result = v;
    waitc(1);
    conv_done = 0;
    chk(busy === exp_busy, exp_busy ? "R6 busy after done" : "R1 busy after done", busy, exp_busy);
  endtask

  task automatic read(input logic [15:0] d, input logic [15:0] x, input int nbits,
                      input bit es, input bit idle, input bit bchk);
    bit pre;
    pre = !es;
    edge_sel = es; sclk = idle; up = x;
    waitc(2);
    cs_n = 0;
    waitc(2);
    for (int k = 0; k < nbits; k++) begin
      bit e;
      e = (k < 16) ? d[15-k] : ((k < 32) ? x[31-k] : 1'b0);
      push(e, (k < 16) ? "R3 R4 R7 bit" : "R5 chain bit");
      if (sclk != pre) begin
        sclk = pre;
        waitc(2);
        push(e, "R4 hold across capture edge");
      end
      if (bchk) chk(busy === (k < 16), "R6 busy during read", busy, k < 16);
      sclk = ~pre;
      up = {up[14:0], 1'b0};
      waitc(2);
    end
    if (bchk) chk(busy === (nbits < 16), "R6 busy after read", busy, nbits < 16);
    sclk = idle;
    waitc(2);
    cs_n = 1;
    waitc(2);
    chk(sdo === 1'b0, "R9 sdo idle", sdo, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitc(2);
    chk(sdo === 1'b0, "R9 reset sdo", sdo, 0);
    chk(busy === 1'b0, "R6 reset busy", busy, 0);
    rst_n = 1;
    waitc(2);

    convert(16'hA5C3, 1);
    for (int i = 0; i < 4; i++) begin
      sclk = ~sclk; waitc(2);
    end
    chk(sdo === 1'b0, "R9 sclk with cs high", sdo, 0);
    cs_n = 0; rd_n = 1;
    waitc(2);
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk; waitc(2);
    end
    chk(sdo === 1'b1, "R2 gated first bit", sdo, 1);
    chk(busy === 1'b1, "R2 busy unchanged", busy, 1);
    sclk = 0; waitc(2);
    cs_n = 1; rd_n = 0;
    waitc(2);
    read(16'hA5C3, 16'h3C5A, 34, 0, 0, 1);

    convert(16'h8001, 1);
    read(16'h8001, 16'hF00F, 20, 1, 1, 1);

    convert(16'h1234, 1);
    read(16'h1234, 16'h0000, 5, 0, 1, 1);
    read(16'h1234, 16'h0000, 16, 0, 1, 1);

    for (int m = 0; m < 4; m++) begin
      logic [15:0] v;
      v = 16'h6B2D ^ (16'h1111 * m);
      convert(v, 1);
      read(v, 16'hC3A5 ^ 16'(m), 32, m[0], m[1], 1);
    end

    ext_mode = 0;
    convert(16'hFFFF, 0);
    cs_n = 0;
    waitc(2);
    for (int i = 0; i < 8; i++) begin
      sclk = ~sclk; waitc(2);
      chk(sdo === 1'b0, "R1 sdo in disabled mode", sdo, 0);
    end
    chk(busy === 1'b0, "R1 busy in disabled mode", busy, 0);
    cs_n = 1; sclk = 0;
    waitc(2);
    ext_mode = 1;
    waitc(2);
    read(16'hFFFF, 16'h0000, 16, 0, 0, 0);

    waitc(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule